// File: doc/BRIEF.md
# Tagged Receive Buffer with Idle Timeout

This block sits between a serial receive engine and the host. Each character the engine finishes arrives on a one-cycle write strobe with eight data bits and three error tags. The block stores the data and tags together as one entry. The oldest entry is always shown as the holding register, and its tags are always shown as status bits. A host read strobe pops that entry, so the next entry's data and tags appear after the same clock edge.

A mode input selects deep buffering (64 entries) or single-register operation (1 entry). Changing this input empties the buffer. The host sees three signals: a data-ready flag, a level interrupt that fires when the fill count reaches a programmed trigger level, and an idle-timeout interrupt. The timeout is counted in bit-time ticks supplied from outside. It fires when characters are waiting and nothing has been written or read for four character frames plus twelve bits. A character frame is start + data + parity + stop. A write that finds the buffer full is dropped and raises a sticky overrun flag, which the host clears with a status-read strobe.

The idle timer is a three-state machine. `TS_IDLE` means the buffer is empty and nothing counts. `TS_COUNT` means ticks are being counted. `TS_EXPIRED` means the timeout is raised. Transitions:
- Any accepted write, any accepted pop and any flush force `TS_COUNT` with a zero count.
- An empty buffer with no such event forces `TS_IDLE`.
- `TS_IDLE` goes to `TS_COUNT` when the buffer holds data.
- `TS_COUNT` goes to `TS_EXPIRED` on the tick that completes the limit.
- `TS_EXPIRED` holds until a reload or until the buffer is empty.

Top module: `rx_tag_fifo`

## Requirements
- R1: After reset `data_ready`, `overrun`, `lvl_irq` and `tmo_irq` are 0, and `hold_data` and `hold_tags` read 0.
- R2: Entries leave in the order they were accepted. `hold_data`/`hold_tags` show the oldest entry, and both read 0 whenever the buffer is empty (`data_ready` = 0).
- R3: An accepted pop advances the head so that the next entry's data and tags appear on the outputs after that same clock edge.
- R4: With `fifo_on` = 1 the buffer accepts 64 entries. A write arriving at 64 entries is discarded, leaves the stored entries unchanged and sets `overrun`.
- R5: With `fifo_on` = 0 the buffer holds one entry. A second write before a pop is discarded and sets `overrun`.
- R6: `overrun` stays set until a cycle with `stat_rd` = 1 and no overflowing write. An overflow in the same cycle as `stat_rd` leaves it set.
- R7: `lvl_irq` is 1 when the entry count is at least the trigger level: `lvl_sel` 0→1, 1→16, 2→32, 3→56 entries with `fifo_on` = 1, and always 1 entry with `fifo_on` = 0.
- R8: `tmo_irq` rises after L = 4·(8+`wlen_sel`)+12 ticks (44, 48, 52, 56 for codes 0–3) with data held and no accepted write or pop. Each accepted write or pop restarts the count from zero.
- R9: Ticks are not counted while the buffer is empty, and `tmo_irq` is 0 whenever the buffer is empty.
- R10: With `irq_en` = 0 both `lvl_irq` and `tmo_irq` are 0.
- R11: Any change of `fifo_on` empties the buffer. A write in that cycle is dropped without setting `overrun`.
- R12: A pop while empty has no effect. A later write is then shown at the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Character write strobe from the receive engine |
| wr_data | input | 8 | Received character |
| wr_tags | input | 3 | Error tags of the character |
| rd_pop | input | 1 | Host read of the holding register (pops the head) |
| stat_rd | input | 1 | Host read of status (clears overrun) |
| tick | input | 1 | One-cycle pulse per serial bit time |
| fifo_on | input | 1 | 1: 64-entry buffer, 0: single holding register |
| lvl_sel | input | 2 | Trigger level code |
| wlen_sel | input | 2 | Word length code (5 + code data bits) |
| irq_en | input | 1 | Receive interrupt enable |
| hold_data | output | 8 | Head character |
| hold_tags | output | 3 | Head error tags |
| data_ready | output | 1 | Buffer not empty |
| overrun | output | 1 | Sticky overflow flag |
| lvl_irq | output | 1 | Fill level reached trigger level |
| tmo_irq | output | 1 | Idle timeout with data waiting |

## Verification
The assertions check every cycle that an empty buffer shows zero data and tags and never raises a timeout. They also check that the level interrupt implies waiting data, that a clear `irq_en` silences both interrupts, and that overrun stays set without a status read. Only the bench scenarios can show the following:
- ordering of data and tags through a full 64-entry fill and drain;
- the exact capacity and the discarded 65th write;
- the four trigger levels and the exact tick count of the timeout for every word-length code;
- restart of the count on writes;
- single-register mode and the flush on a mode change.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int DATA_W = 8;
    localparam int TAG_W  = 3;
    localparam int TMO_W  = 6;

    typedef struct packed {
        logic [TAG_W-1:0]  tags;
        logic [DATA_W-1:0] data;
    } rxq_entry_t;

    typedef enum logic [1:0] {
        TS_IDLE    = 2'd0,
        TS_COUNT   = 2'd1,
        TS_EXPIRED = 2'd2
    } tmr_state_e;

    // frame bits = start + (5+code) data + parity + stop = 8 + code
    function automatic logic [TMO_W-1:0] idle_limit(input logic [1:0] wl);
        return 6'd44 + {2'b00, wl, 2'b00};
    endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       single,
    input  logic                       wr_en,
    input  rxq_entry_t                 wr_entry,
    input  logic                       rd_pop,
    input  logic                       stat_rd,
    output rxq_entry_t                 head,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       ovr,
    output logic                       wr_ok,
    output logic                       pop_ok
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    rxq_entry_t       mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    cap;
    logic             overflow;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
    endfunction

    assign cap      = single ? CW'(1) : CW'(DEPTH);
    assign wr_ok    = !flush && wr_en && (level < cap);
    assign overflow = !flush && wr_en && (level >= cap);
    assign pop_ok   = !flush && rd_pop && (level != '0);

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_ptr] <= wr_entry;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (wr_ok)  wr_ptr <= bump(wr_ptr);
            if (pop_ok) rd_ptr <= bump(rd_ptr);
            unique case ({wr_ok, pop_ok})
                2'b10:   level <= level + CW'(1);
                2'b01:   level <= level - CW'(1);
                default: level <= level;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ovr <= 1'b0;
        else if (overflow) ovr <= 1'b1;
        else if (stat_rd)  ovr <= 1'b0;
    end

    assign head = (level != '0) ? mem[rd_ptr] : '0;
endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer
    import rxq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reload,
    input  logic       nonempty,
    input  logic       tick,
    input  logic [1:0] wlen_sel,
    output logic       expired
);
    tmr_state_e       st, st_n;
    logic [TMO_W-1:0] cnt, cnt_n;
    logic [TMO_W-1:0] limit;

    assign limit = idle_limit(wlen_sel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= TS_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        if (reload) begin
            st_n  = TS_COUNT;
            cnt_n = '0;
        end else if (!nonempty) begin
            st_n  = TS_IDLE;
            cnt_n = '0;
        end else begin
            unique case (st)
                TS_IDLE: begin
                    st_n  = TS_COUNT;
                    cnt_n = '0;
                end
                TS_COUNT: begin
                    if (tick) begin
                        if (cnt == limit - TMO_W'(1)) begin
                            st_n  = TS_EXPIRED;
                            cnt_n = '0;
                        end else begin
                            cnt_n = cnt + TMO_W'(1);
                        end
                    end
                end
                TS_EXPIRED: begin
                    st_n = TS_EXPIRED;
                end
                default: begin
                    st_n  = TS_IDLE;
                    cnt_n = '0;
                end
            endcase
        end
    end

    always_comb begin
        expired = (st == TS_EXPIRED);
    end
endmodule

// File: rtl/rxq_irq_gen.sv
module rxq_irq_gen #(
    parameter int CW = 7
) (
    input  logic          irq_en,
    input  logic          single,
    input  logic [1:0]    lvl_sel,
    input  logic [CW-1:0] level,
    input  logic          expired,
    output logic          lvl_irq,
    output logic          tmo_irq
);
    logic [CW-1:0] thresh;

    always_comb begin
        if (single) begin
            thresh = CW'(1);
        end else begin
            unique case (lvl_sel)
                2'd0: thresh = CW'(1);
                2'd1: thresh = CW'(16);
                2'd2: thresh = CW'(32);
                2'd3: thresh = CW'(56);
                default: thresh = CW'(1);
            endcase
        end
    end

    assign lvl_irq = irq_en && (level >= thresh);
    assign tmo_irq = irq_en && expired && (level != '0);
endmodule

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    input  logic [2:0]  wr_tags,
    input  logic        rd_pop,
    input  logic        stat_rd,
    input  logic        tick,
    input  logic        fifo_on,
    input  logic [1:0]  lvl_sel,
    input  logic [1:0]  wlen_sel,
    input  logic        irq_en,
    output logic [7:0]  hold_data,
    output logic [2:0]  hold_tags,
    output logic        data_ready,
    output logic        overrun,
    output logic        lvl_irq,
    output logic        tmo_irq
);
    localparam int CW = $clog2(DEPTH+1);

    logic          mode_q, flush, wr_ok, pop_ok, expired;
    logic [CW-1:0] level;
    rxq_entry_t    in_e, head_e;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= 1'b0;
        else        mode_q <= fifo_on;
    end
    assign flush = (mode_q != fifo_on);

    assign in_e.data = wr_data;
    assign in_e.tags = wr_tags;

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush), .single(!fifo_on),
        .wr_en(wr_en), .wr_entry(in_e), .rd_pop(rd_pop), .stat_rd(stat_rd),
        .head(head_e), .level(level), .ovr(overrun),
        .wr_ok(wr_ok), .pop_ok(pop_ok)
    );

    rxq_idle_timer u_timer (
        .clk(clk), .rst_n(rst_n), .reload(wr_ok | pop_ok | flush),
        .nonempty(level != '0), .tick(tick), .wlen_sel(wlen_sel),
        .expired(expired)
    );

    rxq_irq_gen #(.CW(CW)) u_irq (
        .irq_en(irq_en), .single(!fifo_on), .lvl_sel(lvl_sel),
        .level(level), .expired(expired),
        .lvl_irq(lvl_irq), .tmo_irq(tmo_irq)
    );

    assign hold_data  = head_e.data;
    assign hold_tags  = head_e.tags;
    assign data_ready = (level != '0);
endmodule

// File: rtl/rx_tag_fifo_chk.sv
module rx_tag_fifo_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       irq_en,
    input logic       stat_rd,
    input logic [7:0] hold_data,
    input logic [2:0] hold_tags,
    input logic       data_ready,
    input logic       overrun,
    input logic       lvl_irq,
    input logic       tmo_irq
);
    AST_EMPTY_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !data_ready |-> (hold_data == 8'd0 && hold_tags == 3'd0)); // R2

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !stat_rd) |=> overrun); // R6

    AST_LVL_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_irq |-> data_ready); // R7

    AST_EMPTY_NO_TMO: assert property (@(posedge clk) disable iff (!rst_n)
        !data_ready |-> !tmo_irq); // R9

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> (!lvl_irq && !tmo_irq)); // R10
endmodule

bind rx_tag_fifo rx_tag_fifo_chk u_chk (
    .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .stat_rd(stat_rd),
    .hold_data(hold_data), .hold_tags(hold_tags), .data_ready(data_ready),
    .overrun(overrun), .lvl_irq(lvl_irq), .tmo_irq(tmo_irq)
);

// File: tb/rx_tag_fifo_test.sv
module rx_tag_fifo_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_pop = 1'b0, stat_rd = 1'b0, tick = 1'b0;
    logic [7:0] wr_data = '0;
    logic [2:0] wr_tags = '0;
    logic       fifo_on = 1'b1, irq_en = 1'b1;
    logic [1:0] lvl_sel = '0, wlen_sel = '0;
    logic [7:0] hold_data;
    logic [2:0] hold_tags;
    logic       data_ready, overrun, lvl_irq, tmo_irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    rx_tag_fifo uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_tags(wr_tags), .rd_pop(rd_pop), .stat_rd(stat_rd), .tick(tick),
        .fifo_on(fifo_on), .lvl_sel(lvl_sel), .wlen_sel(wlen_sel),
        .irq_en(irq_en), .hold_data(hold_data), .hold_tags(hold_tags),
        .data_ready(data_ready), .overrun(overrun), .lvl_irq(lvl_irq),
        .tmo_irq(tmo_irq)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] d, input logic [2:0] t);
        wr_en = 1'b1; wr_data = d; wr_tags = t;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pop();
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
        end
        tick = 1'b0;
    endtask

    task automatic drain();
        while (data_ready) pop();
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 data_ready", data_ready, 0);
        check("R1 overrun", overrun, 0);
        check("R1 lvl_irq", lvl_irq, 0);
        check("R1 tmo_irq", tmo_irq, 0);
        check("R1 hold_data", hold_data, 0);
        check("R1 hold_tags", hold_tags, 0);
    endtask

    function automatic int lvl_of(input int s);
        case (s)
            0: return 1;
            1: return 16;
            2: return 32;
            default: return 56;
        endcase
    endfunction

    task automatic t_fill_drain();
        fifo_on = 1'b1; irq_en = 1'b1;
        for (int s = 0; s < 4; s++) begin
            lvl_sel = 2'(s); #1;
            check("R7 empty level", lvl_irq, 0);
        end
        for (int k = 1; k <= 64; k++) begin
            put(8'(k + 8'h40), 3'(k % 8));
            if (k == 1 || k == 15 || k == 16 || k == 31 || k == 32 || k == 55 || k == 56) begin
                for (int s = 0; s < 4; s++) begin
                    lvl_sel = 2'(s); #1;
                    check("R7 trigger level", lvl_irq, (k >= lvl_of(s)) ? 1 : 0);
                end
            end
        end
        check("R4 no overrun at 64", overrun, 0);
        put(8'hEE, 3'd7);
        check("R4 overrun on 65th", overrun, 1);
        for (int k = 1; k <= 64; k++) begin
            check("R2 head data order", hold_data, (k + 8'h40) % 256);
            check("R3 head tags", hold_tags, k % 8);
            pop();
        end
        check("R4 65th discarded", data_ready, 0);
        check("R2 empty data zero", hold_data, 0);
        lvl_sel = 2'd0;
    endtask

    task automatic t_overrun_clear();
        check("R6 still set", overrun, 1);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        check("R6 cleared by status read", overrun, 0);
        fifo_on = 1'b0;
        @(negedge clk);
        put(8'h11, 3'd1);
        wr_en = 1'b1; wr_data = 8'h22; stat_rd = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; stat_rd = 1'b0;
        check("R6 set wins over clear", overrun, 1);
        drain();
        check("R6 clear after drain", overrun, 0);
    endtask

    task automatic t_single();
        fifo_on = 1'b0; lvl_sel = 2'd3;
        @(negedge clk);
        put(8'hA5, 3'd5);
        check("R7 single level 1", lvl_irq, 1);
        put(8'h5A, 3'd2);
        check("R5 second write overruns", overrun, 1);
        check("R5 head kept", hold_data, 8'hA5);
        check("R5 head tags kept", hold_tags, 5);
        pop();
        check("R5 one entry only", data_ready, 0);
        drain();
        fifo_on = 1'b1; lvl_sel = 2'd0;
        @(negedge clk);
        put(8'h01, 3'd0); put(8'h02, 3'd0); put(8'h03, 3'd0);
        fifo_on = 1'b0; wr_en = 1'b1; wr_data = 8'h77;
        @(negedge clk);
        wr_en = 1'b0;
        check("R11 mode change empties", data_ready, 0);
        check("R11 no overrun", overrun, 0);
        fifo_on = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_timeout();
        fifo_on = 1'b1; irq_en = 1'b1;
        for (int w = 0; w < 4; w++) begin
            int lim;
            wlen_sel = 2'(w);
            lim = 4 * (8 + w) + 12;
            put(8'h30, 3'd0);
            ticks(lim - 1);
            check("R8 no timeout before limit", tmo_irq, 0);
            ticks(1);
            check("R8 timeout at limit", tmo_irq, 1);
            pop();
            check("R9 timeout gone when empty", tmo_irq, 0);
        end
        wlen_sel = 2'd0;
        put(8'h31, 3'd0);
        ticks(30);
        put(8'h32, 3'd0);
        ticks(43);
        check("R8 write restarts count", tmo_irq, 0);
        ticks(1);
        check("R8 timeout after restart", tmo_irq, 1);
        pop();
        ticks(43);
        check("R8 pop restarts count", tmo_irq, 0);
        ticks(1);
        check("R8 timeout after pop restart", tmo_irq, 1);
        pop();
        ticks(60);
        check("R9 empty no timeout", tmo_irq, 0);
        put(8'h33, 3'd0);
        ticks(43);
        check("R9 no ticks counted while empty", tmo_irq, 0);
        ticks(1);
        check("R9 fresh count", tmo_irq, 1);
        irq_en = 1'b0; #1;
        check("R10 timeout gated", tmo_irq, 0);
        check("R10 level gated", lvl_irq, 0);
        irq_en = 1'b1; #1;
        check("R10 enable restores", tmo_irq, 1);
        pop();
    endtask

    task automatic t_empty_pop();
        pop();
        pop();
        check("R12 pop empty no effect", data_ready, 0);
        put(8'h9C, 3'd6);
        check("R12 head after empty pops", hold_data, 8'h9C);
        check("R12 head tags", hold_tags, 6);
        pop();
        check("R12 empty again", data_ready, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill_drain();
        t_overrun_clear();
        t_single();
        t_timeout();
        t_empty_pop();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule